// File: doc/BRIEF.md
# Status Flag Clear Sequencer

This block holds four sticky event flags of a two-wire serial bus controller and implements the access sequences that software uses to clear them. Each flag is raised by a one-cycle event from the protocol engine. Software lowers a flag in two steps. The first step is always a read of the first status register. The second step is an access that depends on the flag. Decoded one-cycle strobes for register reads and writes come in from the register file, and the flag values go back to it.

Each flag has a private armed bit that records that the first step has happened. A flag drops only when its armed bit is set and its own second access arrives. An event on the same cycle as that access keeps the flag high. The address flag is different from the others. Any first-status read arms it, even when the flag is still low, so a flag raised between the two reads is cleared by the second read. Driving the enable low drops every flag and every armed bit, and it blocks all set events.

Top module: `flag_clear_seq`

## Requirements
- R1: While rstN is low, and on the first cycle after reset, flags is 4'b0000. Bit positions are: bit 0 start-generated, bit 1 address-done, bit 2 header-sent, bit 3 stop-seen.
- R2: A one-cycle evStart pulse with enable high sets flags[0] on the next clock edge. evAck has no effect on this.
- R3: flags[0] clears on the clock edge of a wrData strobe, if an rdStat1 strobe came earlier while the flag was high.
- R4: flags[1] clears on an rdStat3 strobe that follows any rdStat1 strobe, even when the flag was low at the time of the rdStat1 read.
- R5: flags[2] clears on a wrData strobe that follows an rdStat1 read made while the flag was high. wrCtrl2 and rdStat3 do not clear it.
- R6: flags[3] clears on a wrCtrl2 strobe that follows an rdStat1 read made while the flag was high.
- R7: evAddr, evHdr and evStop set their flags (bits 1, 2, 3) only when evAck is high in the same cycle. With evAck low they are ignored.
- R8: If no arming rdStat1 read came before it, the second access leaves the flag set. For bits 0, 2 and 3, an rdStat1 read made while the flag is low and no event is present does not arm.
- R9: A set event in the same cycle as an armed clearing access keeps the flag at 1.
- R10: With enable low, flags reads 0 on the next edge, set events are ignored, and all armed bits are dropped. A later second access without a new rdStat1 read does not clear a flag.
- R11: An rdStat1 read in the same cycle as a set event arms that flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Peripheral enable; low forces all flags and armed bits clear |
| rdStat1 | input | 1 | Read strobe, first status register |
| rdStat3 | input | 1 | Read strobe, third status register |
| wrData | input | 1 | Write strobe, data register |
| wrCtrl2 | input | 1 | Write strobe, second control register |
| evStart | input | 1 | Start condition generated |
| evAddr | input | 1 | Address phase finished |
| evHdr | input | 1 | 10-bit header byte sent |
| evStop | input | 1 | Stop condition detected |
| evAck | input | 1 | Acknowledge received with the current event |
| flags | output | 4 | Flag values: start, address, header, stop (bit 0 to 3) |

## Verification
The bench goes after the address flag set between the two reads. A design that arms only on a high flag would leave that flag stuck. It checks that a wrong second access, such as a control write for the header flag, leaves the flag alone, because a design that shares one armed bit across flags would clear it. It also drives a set event together with the clearing access, which would drop a real event if the clear won. Further checks cover disabling between the two steps, which would clear later without a fresh read if armed state survived, and a NACK event, which must leave the flag low.

// File: rtl/flag_seq_pkg.sv
package flag_seq_pkg;
  localparam int NUM_FLAGS = 4;

  localparam int FL_START = 0;
  localparam int FL_ADDR  = 1;
  localparam int FL_HDR   = 2;
  localparam int FL_STOP  = 3;

  typedef enum logic [1:0] {
    ACC_STAT3  = 2'd0,
    ACC_DATA   = 2'd1,
    ACC_CTRL2  = 2'd2
  } acc_kind_e;

  // strobes from control to the flag datapath
  typedef struct packed {
    logic                 live;
    logic                 armReq;
    logic [NUM_FLAGS-1:0] setReq;
    logic [NUM_FLAGS-1:0] clrReq;
  } flag_strb_t;

  // flags armed by any first-status read, raised or not
  localparam logic [NUM_FLAGS-1:0] ARM_ALWAYS = 4'b0010;
  // flags whose set event requires an acknowledge
  localparam logic [NUM_FLAGS-1:0] NEED_ACK   = 4'b1110;

  function automatic acc_kind_e secondAccess(input int idx);
    case (idx)
      FL_ADDR: return ACC_STAT3;
      FL_STOP: return ACC_CTRL2;
      default: return ACC_DATA;
    endcase
  endfunction
endpackage

// File: rtl/flag_seq_ctrl.sv
module flag_seq_ctrl
  import flag_seq_pkg::*;
#(
  parameter int N = NUM_FLAGS,
  parameter logic [N-1:0] ACK_MASK = NEED_ACK
) (
  input  logic         enable,
  input  logic         rdStat1,
  input  logic         rdStat3,
  input  logic         wrData,
  input  logic         wrCtrl2,
  input  logic [N-1:0] evRaw,
  input  logic         evAck,
  output flag_strb_t   strb
);
  logic [2:0] accVec;

  always_comb begin
    accVec = '0;
    accVec[ACC_STAT3] = rdStat3;
    accVec[ACC_DATA]  = wrData;
    accVec[ACC_CTRL2] = wrCtrl2;
  end

  assign strb.live   = enable;
  assign strb.armReq = enable & rdStat1;

  for (genvar i = 0; i < N; i++) begin : g_dec
    localparam acc_kind_e KIND = secondAccess(i);
    if (ACK_MASK[i]) begin : g_ack
      assign strb.setReq[i] = enable & evRaw[i] & evAck;
    end else begin : g_noack
      assign strb.setReq[i] = enable & evRaw[i];
    end
    assign strb.clrReq[i] = enable & accVec[KIND];
  end
endmodule

// File: rtl/flag_seq_regs.sv
module flag_seq_regs
  import flag_seq_pkg::*;
#(
  parameter int N = NUM_FLAGS,
  parameter logic [N-1:0] ARM_MASK = ARM_ALWAYS
) (
  input  logic         clk,
  input  logic         rstN,
  input  flag_strb_t   strb,
  output logic [N-1:0] flagQ
);
  logic [N-1:0] armQ;

  for (genvar i = 0; i < N; i++) begin : g_flag
    logic armHit;
    logic doClear;

    assign armHit  = ARM_MASK[i] | flagQ[i] | strb.setReq[i];
    assign doClear = armQ[i] & strb.clrReq[i] & ~strb.setReq[i];

    always_ff @(posedge clk) begin
      if (!rstN || !strb.live) begin
        flagQ[i] <= 1'b0;
        armQ[i]  <= 1'b0;
      end else begin
        if (strb.setReq[i])  flagQ[i] <= 1'b1;
        else if (doClear)    flagQ[i] <= 1'b0;

        if (strb.armReq)          armQ[i] <= armHit;
        else if (strb.clrReq[i])  armQ[i] <= 1'b0;
      end
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
      strb.live && strb.setReq[i] |=> flagQ[i]) else $error("set lost"); // R9

    AST_CLEAR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rstN)
      $fell(flagQ[i]) && $past(strb.live) |-> $past(armQ[i]) && $past(strb.clrReq[i])) else $error("unarmed clear"); // R8

    AST_ARM_FROM_READ: assert property (@(posedge clk) disable iff (!rstN)
      $rose(armQ[i]) |-> $past(strb.armReq)) else $error("arm without read"); // R11
  end

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !strb.live |=> flagQ == '0 && armQ == '0) else $error("disable leak"); // R10
endmodule

// File: rtl/flag_clear_seq.sv
module flag_clear_seq
  import flag_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       rdStat1,
  input  logic       rdStat3,
  input  logic       wrData,
  input  logic       wrCtrl2,
  input  logic       evStart,
  input  logic       evAddr,
  input  logic       evHdr,
  input  logic       evStop,
  input  logic       evAck,
  output logic [3:0] flags
);
  flag_strb_t strb;
  logic [NUM_FLAGS-1:0] evRaw;

  assign evRaw = {evStop, evHdr, evAddr, evStart};

  flag_seq_ctrl #(.N(NUM_FLAGS), .ACK_MASK(NEED_ACK)) u_ctrl (
    .enable (enable),
    .rdStat1(rdStat1),
    .rdStat3(rdStat3),
    .wrData (wrData),
    .wrCtrl2(wrCtrl2),
    .evRaw  (evRaw),
    .evAck  (evAck),
    .strb   (strb)
  );

  flag_seq_regs #(.N(NUM_FLAGS), .ARM_MASK(ARM_ALWAYS)) u_regs (
    .clk  (clk),
    .rstN (rstN),
    .strb (strb),
    .flagQ(flags)
  );

  AST_NACK_NO_SET: assert property (@(posedge clk) disable iff (!rstN)
    !evAck && !flags[FL_STOP] |=> !flags[FL_STOP]) else $error("nack set"); // R7

  AST_START_SETS: assert property (@(posedge clk) disable iff (!rstN)
    enable && evStart |=> flags[FL_START]) else $error("start missed"); // R2
endmodule

// File: tb/tb_flag_clear_seq.sv
`timescale 1ns/1ps
module tb_flag_clear_seq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable, rdStat1, rdStat3, wrData, wrCtrl2;
  logic evStart, evAddr, evHdr, evStop, evAck;
  logic [3:0] flags;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  flag_clear_seq dut (
    .clk(clk), .rstN(rstN), .enable(enable),
    .rdStat1(rdStat1), .rdStat3(rdStat3), .wrData(wrData), .wrCtrl2(wrCtrl2),
    .evStart(evStart), .evAddr(evAddr), .evHdr(evHdr), .evStop(evStop),
    .evAck(evAck), .flags(flags)
  );

  // stimulus bit positions
  localparam int S_EN = 9, S_ACK = 8, S_RD1 = 7, S_RD3 = 6, S_WRD = 5;
  localparam int S_WC2 = 4, S_ST = 3, S_AD = 2, S_HD = 1, S_SP = 0;

  logic [3:0] mFlag, mArm;

  // expected next state, derived from the requirement list
  function automatic logic [7:0] modelNext(input logic [3:0] f, input logic [3:0] a,
                                           input logic [9:0] s);
    logic [3:0] nf, na, ev, sec;
    ev  = {s[S_SP], s[S_HD], s[S_AD], s[S_ST]};
    sec = {s[S_WC2], s[S_WRD], s[S_RD3], s[S_WRD]};
    nf = f; na = a;
    if (!s[S_EN]) return 8'h00;
    for (int i = 0; i < 4; i++) begin
      logic setNow;
      setNow = ev[i] && (i == 0 || s[S_ACK]);
      if (setNow) nf[i] = 1'b1;
      else if (a[i] && sec[i]) nf[i] = 1'b0;
      if (s[S_RD1]) na[i] = (i == 1) || f[i] || setNow;
      else if (sec[i]) na[i] = 1'b0;
    end
    return {na, nf};
  endfunction

  task automatic drive(input logic [9:0] s);
    enable = s[S_EN]; evAck = s[S_ACK]; rdStat1 = s[S_RD1]; rdStat3 = s[S_RD3];
    wrData = s[S_WRD]; wrCtrl2 = s[S_WC2]; evStart = s[S_ST]; evAddr = s[S_AD];
    evHdr = s[S_HD]; evStop = s[S_SP];
  endtask

  task automatic chk(input string tag, input logic [3:0] exp);
    total++;
    if (flags !== exp) begin
      bad++;
      $display("FAIL %s: flags=%b expected=%b", tag, flags, exp);
    end
  endtask

  // one cycle: called at a negedge, returns at the next negedge
  task automatic step(input logic [9:0] s);
    logic [7:0] nx;
    drive(s);
    nx = modelNext(mFlag, mArm, s);
    @(negedge clk);
    mFlag = nx[3:0]; mArm = nx[7:4];
    chk("model R2 R7 R9", mFlag);
  endtask

  localparam logic [9:0] EN = 10'b1 << S_EN;
  localparam logic [9:0] AK = 10'b1 << S_ACK;
  localparam logic [9:0] RD1 = 10'b1 << S_RD1;
  localparam logic [9:0] RD3 = 10'b1 << S_RD3;
  localparam logic [9:0] WRD = 10'b1 << S_WRD;
  localparam logic [9:0] WC2 = 10'b1 << S_WC2;
  localparam logic [9:0] ST = 10'b1 << S_ST;
  localparam logic [9:0] AD = 10'b1 << S_AD;
  localparam logic [9:0] HD = 10'b1 << S_HD;
  localparam logic [9:0] SP = 10'b1 << S_SP;

  initial begin
    #2000000;
    bad++;
    $display("FAIL watchdog: flags=%b expected=done", flags);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    drive(10'b0);
    mFlag = '0; mArm = '0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", 4'b0000);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after reset", 4'b0000);

    // R2 / R3 / R8
    step(EN | ST);            chk("R2 start set", 4'b0001);
    step(EN | WRD);           chk("R8 unarmed write keeps start", 4'b0001);
    step(EN | RD1);
    step(EN | WRD);           chk("R3 start cleared", 4'b0000);

    // R4: armed by read while address flag still low
    step(EN | RD1);
    step(EN | AK | AD);       chk("R4 addr set", 4'b0010);
    step(EN | RD3);           chk("R4 addr cleared", 4'b0000);

    // R7
    step(EN | AD | HD | SP);  chk("R7 nack ignored", 4'b0000);

    // R5
    step(EN | AK | HD);       chk("R5 hdr set", 4'b0100);
    step(EN | RD1);
    step(EN | WC2);           chk("R5 ctrl write keeps hdr", 4'b0100);
    step(EN | RD3);           chk("R5 stat3 read keeps hdr", 4'b0100);
    step(EN | WRD);           chk("R5 hdr cleared", 4'b0000);

    // R6
    step(EN | AK | SP);       chk("R6 stop set", 4'b1000);
    step(EN | RD1);
    step(EN | WC2);           chk("R6 stop cleared", 4'b0000);

    // R8: read while low does not arm
    step(EN | RD1);
    step(EN | AK | SP);
    step(EN | WC2);           chk("R8 read-while-low no arm", 4'b1000);
    step(EN | RD1);
    step(EN | WC2);           chk("R6 stop cleared again", 4'b0000);
    step(EN | RD3);

    // R9
    step(EN | ST);
    step(EN | RD1);
    step(EN | WRD | ST);      chk("R9 set beats clear", 4'b0001);
    step(EN | RD1);
    step(EN | WRD);           chk("R9 cleanup", 4'b0000);

    // R11
    step(EN | RD1 | ST);      chk("R11 set with read", 4'b0001);
    step(EN | WRD);           chk("R11 armed by same-cycle read", 4'b0000);

    // R10
    step(EN | ST | AK | SP);  chk("R10 setup", 4'b1001);
    step(EN | RD1);
    step(10'b0);              chk("R10 disable clears", 4'b0000);
    step(ST | AK | SP);       chk("R10 sets ignored", 4'b0000);
    step(EN | AK | SP);
    step(EN | WC2);           chk("R10 arm dropped", 4'b1000);
    step(EN | RD1);
    step(EN | WC2);

    // constrained random against the model
    for (int n = 0; n < 4000; n++) begin
      logic [9:0] s;
      s = 10'($urandom);
      s[S_EN] = ($urandom_range(0, 15) != 0);
      s[S_ST] = ($urandom_range(0, 5) == 0);
      s[S_AD] = ($urandom_range(0, 5) == 0);
      s[S_HD] = ($urandom_range(0, 5) == 0);
      s[S_SP] = ($urandom_range(0, 5) == 0);
      step(s);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule